// File: doc/BRIEF.md
# Single-Bank Bit-Reversal Reorder Buffer

This block sits behind a parallel-path pipelined FFT. The FFT emits its frames in bit-reversed index order, several lanes per clock and with no pause between frames. The block turns each frame into natural index order. It uses one memory that holds exactly one frame of N samples.

On every input beat, each memory column is read at one row, and the incoming sample for that column is written into the same row in the same beat. The read returns the sample that the previous frame left there. To make this work, the slot mapping switches between two schemes on alternating frames. In the even scheme the row is the beat position. The odd scheme is the even one composed with the full bit reversal. Within a beat, each lane lands in a different column because the column is the lane index XOR-ed with the top bits of the beat position. A lane crossbar on each side of the memory routes lanes to their columns and back.

An output beat follows its input beat by one clock. A frame therefore comes out during the beats of the frame that follows it.

Top module: `brrb_reorder`

## Requirements
- R1: With N = 2^n points over P = 2^b lanes, input beat t of a frame carries in lane l (bits `[l*SAMP_W +: SAMP_W]`) the sample whose index is the n-bit reversal of t*P+l. Output lane l of the matching output beat carries sample t*P+l of the previously completed frame.
- R2: An output beat appears one clock after the input beat that produced it. The samples of frame k emerge during the beats of frame k+1.
- R3: During the first frame after reset, `out_valid_o` stays low.
- R4: Once one full frame is stored, every input beat of continuous back-to-back frames yields an output beat, with no gap at frame boundaries.
- R5: A beat with `in_sof_i` high while the position counter is not 0 restarts at position 0. `out_valid_o` then stays low until a full frame has been written after the restart.
- R6: A clock with `in_valid_i` low produces no output beat and does not advance the frame position, so idle clocks may fall anywhere inside a frame.
- R7: `out_data_o` keeps its value on any clock that follows a clock with `in_valid_i` low.
- R8: After reset, `out_valid_o` is 0 and `out_data_o` is all zeros.
- R9: After position P-1... more precisely, after position N/P-1 the position wraps to 0 by itself. A new frame may begin without `in_sof_i` and is reordered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat qualifier |
| in_sof_i | input | 1 | First beat of a frame, sampled with `in_valid_i` |
| in_data_i | input | LANES*SAMP_W | Input lanes in bit-reversed order |
| out_valid_o | output | 1 | Output beat qualifier |
| out_data_o | output | LANES*SAMP_W | Output lanes in natural order |

## Verification
The bench tags every sample with its frame number and its index. This exposes any mix-up between the two addressing schemes. If the parity were wrong, or a crossbar were missing or mirrored, samples would come out in the wrong lane or from the wrong frame.

Frames follow each other with no gap, so a read-after-write ordering error would show up as samples of the current frame appearing in place of the previous one. Idle clocks placed inside a frame would catch a counter that advances without a beat.

A start flag placed mid-frame checks that output is suppressed for a whole refill rather than only for the damaged frame. A frame that begins without a start flag checks that the position wraps by itself.

// File: rtl/brrb_pkg.sv
package brrb_pkg;
  // reverse the low w bits of v
  function automatic logic [15:0] rev_bits(input logic [15:0] v, input int unsigned w);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(w)) r[i] = v[int'(w) - 1 - i];
    end
    return r;
  endfunction
endpackage

// File: rtl/brrb_seq.sv
module brrb_seq #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_sof_i,
  output logic [ROW_W-1:0] pos_o,
  output logic             odd_o,
  output logic             emit_o
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] cnt_q;
  logic             par_q;
  logic             full_q;
  logic             resync;

  assign pos_o  = in_sof_i ? '0 : cnt_q;
  assign resync = in_sof_i && (cnt_q != '0);
  assign odd_o  = (pos_o == '0) ? ~par_q : par_q;
  assign emit_o = in_valid_i && full_q && !resync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      par_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (in_valid_i) begin
      cnt_q <= (pos_o == LAST) ? '0 : pos_o + 1'b1;
      par_q <= odd_o;
      if (resync)              full_q <= 1'b0;
      else if (pos_o == LAST)  full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/brrb_addr.sv
module brrb_addr
  import brrb_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned LANE_W = $clog2(LANES),
  parameter int unsigned LO_W   = ROW_W - LANE_W
) (
  input  logic [ROW_W-1:0]              pos_i,
  input  logic                          odd_i,
  output logic [LANES-1:0][ROW_W-1:0]   row_o,
  output logic [LANES-1:0][LANE_W-1:0]  lane_of_col_o,
  output logic [LANES-1:0][LANE_W-1:0]  col_of_lane_o
);
  logic [LANE_W-1:0] t_hi, t_hi_r;
  logic [LO_W-1:0]   t_lo_r;

  assign t_hi   = pos_i[ROW_W-1 -: LANE_W];
  assign t_hi_r = LANE_W'(rev_bits(16'(t_hi), LANE_W));
  assign t_lo_r = LO_W'(rev_bits(16'(pos_i[LO_W-1:0]), LO_W));

  for (genvar c = 0; c < LANES; c++) begin : g_col
    localparam logic [LANE_W-1:0] C   = LANE_W'(c);
    localparam logic [LANE_W-1:0] C_R = LANE_W'(rev_bits(16'(c), LANE_W));
    always_comb begin
      if (odd_i) begin
        lane_of_col_o[c] = C_R ^ t_hi;
        row_o[c]         = {C ^ t_hi_r, t_lo_r};
      end else begin
        lane_of_col_o[c] = C ^ t_hi;
        row_o[c]         = pos_i;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] x;
    assign x = LANE_W'(l) ^ t_hi;
    assign col_of_lane_o[l] = odd_i ? LANE_W'(rev_bits(16'(x), LANE_W)) : x;
  end
endmodule

// File: rtl/brrb_mem.sv
module brrb_mem #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned ROWS   = 64,
  parameter int unsigned SAMP_W = 32,
  parameter int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic                           clk_i,
  input  logic                           we_i,
  input  logic [LANES-1:0][ROW_W-1:0]    row_i,
  input  logic [LANES-1:0][SAMP_W-1:0]   wdata_i,
  output logic [LANES-1:0][SAMP_W-1:0]   rdata_o
);
  for (genvar c = 0; c < LANES; c++) begin : g_col
    logic [SAMP_W-1:0] mem [ROWS];
    // old content out, new content in, same row
    assign rdata_o[c] = mem[row_i[c]];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[row_i[c]] <= wdata_i[c];
    end
  end
endmodule

// File: rtl/brrb_reorder.sv
module brrb_reorder #(
  parameter int unsigned N_PTS  = 512,
  parameter int unsigned LANES  = 8,
  parameter int unsigned SAMP_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic                      in_sof_i,
  input  logic [LANES*SAMP_W-1:0]   in_data_i,
  output logic                      out_valid_o,
  output logic [LANES*SAMP_W-1:0]   out_data_o
);
  localparam int unsigned ROWS   = N_PTS / LANES;
  localparam int unsigned ROW_W  = $clog2(ROWS);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [ROW_W-1:0]                pos;
  logic                            odd, emit;
  logic [LANES-1:0][ROW_W-1:0]     row;
  logic [LANES-1:0][LANE_W-1:0]    lane_of_col, col_of_lane;
  logic [LANES-1:0][SAMP_W-1:0]    in_lane, wdata, rdata, out_lane;

  brrb_seq #(.ROWS(ROWS), .ROW_W(ROW_W)) u_seq (
    .clk_i, .rst_ni, .in_valid_i, .in_sof_i,
    .pos_o(pos), .odd_o(odd), .emit_o(emit)
  );

  brrb_addr #(.LANES(LANES), .ROW_W(ROW_W), .LANE_W(LANE_W)) u_addr (
    .pos_i(pos), .odd_i(odd), .row_o(row),
    .lane_of_col_o(lane_of_col), .col_of_lane_o(col_of_lane)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_xbar
    assign in_lane[i]  = in_data_i[i*SAMP_W +: SAMP_W];
    assign wdata[i]    = in_lane[lane_of_col[i]];
    assign out_lane[i] = rdata[col_of_lane[i]];
  end

  brrb_mem #(.LANES(LANES), .ROWS(ROWS), .SAMP_W(SAMP_W), .ROW_W(ROW_W)) u_mem (
    .clk_i, .we_i(in_valid_i), .row_i(row), .wdata_i(wdata), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= emit;
      if (in_valid_i) out_data_o <= out_lane;
    end
  end
endmodule

// File: rtl/brrb_reorder_chk.sv
module brrb_reorder_chk #(
  parameter int unsigned N_PTS  = 512,
  parameter int unsigned LANES  = 8,
  parameter int unsigned SAMP_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_sof_i,
  input logic [LANES*SAMP_W-1:0] in_data_i,
  input logic                    out_valid_o,
  input logic [LANES*SAMP_W-1:0] out_data_o
);
  localparam int unsigned ROWS  = N_PTS / LANES;
  localparam int unsigned ROW_W = $clog2(ROWS);

  logic [ROW_W-1:0] ch_pos;
  logic             ch_full, mid_sof, may_emit;
  logic [ROW_W-1:0] beat_pos;

  assign mid_sof  = in_valid_i && in_sof_i && (ch_pos != '0);
  assign beat_pos = in_sof_i ? '0 : ch_pos;
  assign may_emit = in_valid_i && ch_full && !mid_sof;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_pos  <= '0;
      ch_full <= 1'b0;
    end else if (in_valid_i) begin
      ch_pos <= (int'(beat_pos) == ROWS - 1) ? '0 : beat_pos + 1'b1;
      if (mid_sof)                          ch_full <= 1'b0;
      else if (int'(beat_pos) == ROWS - 1)  ch_full <= 1'b1;
    end
  end

  // R3
  fill_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(may_emit));

  // R2
  one_clk_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  // R5
  resync_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_sof |=> !out_valid_o);

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));
endmodule

bind brrb_reorder brrb_reorder_chk #(.N_PTS(N_PTS), .LANES(LANES), .SAMP_W(SAMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_sof_i(in_sof_i),
  .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
);

// File: tb/sim_brrb_reorder.sv
module sim_brrb_reorder;
  localparam int N  = 64;
  localparam int P  = 4;
  localparam int DW = 16;
  localparam int NB = 6;
  localparam int ROWS = N / P;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_sof_i = 1'b0;
  logic [P*DW-1:0] in_data_i = '0;
  logic out_valid_o;
  logic [P*DW-1:0] out_data_o;

  always #2.5 clk_i = ~clk_i;

  brrb_reorder #(.N_PTS(N), .LANES(P), .SAMP_W(DW)) u0 (
    .clk_i, .rst_ni, .in_valid_i, .in_sof_i, .in_data_i, .out_valid_o, .out_data_o
  );

  int checks = 0, fails = 0;
  int m_cnt = 0, m_prev = 0, m_cur = 0;
  bit m_full = 0, e_valid = 0, e_hold = 1;
  logic [P*DW-1:0] e_data = '0, last_seen = '0;
  string e_tag = "R8";

  function automatic int brev(input int v, input int w);
    int r = 0;
    for (int i = 0; i < w; i++) if (v[i]) r |= 1 << (w - 1 - i);
    return r;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid_o !== e_valid) begin
      fails++;
      $display("FAIL %s valid: got %0b exp %0b", e_tag, out_valid_o, e_valid);
    end
    if (e_valid) begin
      checks++;
      if (out_data_o !== e_data) begin
        fails++;
        $display("FAIL R1 R2 %s data: got %h exp %h", e_tag, out_data_o, e_data);
      end
    end
    if (e_hold) begin
      checks++;
      if (out_data_o !== last_seen) begin
        fails++;
        $display("FAIL R7 %s hold: got %h exp %h", e_tag, out_data_o, last_seen);
      end
    end
    last_seen = out_data_o;
  endtask

  task automatic step(input bit v, input bit sof, input int id, input int t, input string tag);
    int pos;
    bit rs;
    @(negedge clk_i);
    check_out();
    in_valid_i = v;
    in_sof_i   = sof;
    for (int l = 0; l < P; l++) in_data_i[l*DW +: DW] = DW'(id * 256 + brev(t * P + l, NB));
    e_tag = tag;
    if (v) begin
      pos = sof ? 0 : m_cnt;
      rs  = sof && (m_cnt != 0);
      if (pos == 0) begin m_prev = m_cur; m_cur = id; end
      e_valid = m_full && !rs;
      e_hold  = 0;
      for (int l = 0; l < P; l++) e_data[l*DW +: DW] = DW'(m_prev * 256 + pos * P + l);
      if (rs) m_full = 0;
      else if (pos == ROWS - 1) m_full = 1;
      m_cnt = (pos == ROWS - 1) ? 0 : pos + 1;
    end else begin
      e_valid = 0;
      e_hold  = 1;
    end
  endtask

  task automatic frame(input int id, input bit sof, input int beats, input bit gaps, input string tag);
    for (int t = 0; t < beats; t++) begin
      if (gaps && (t % 5 == 2)) begin
        step(0, 0, id, t, "R6");
        step(0, 0, id, t, "R6");
      end
      step(1, sof && (t == 0), id, t, tag);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0 || out_data_o !== '0) begin
      fails++;
      $display("FAIL R8 reset: got %0b/%h exp 0/0", out_valid_o, out_data_o);
    end
    rst_ni = 1'b1;
    frame(1, 1, ROWS, 0, "R3");
    frame(2, 1, ROWS, 0, "R4");
    frame(3, 1, ROWS, 0, "R4");
    frame(4, 1, ROWS, 0, "R4");
    frame(5, 1, ROWS, 1, "R6");
    frame(6, 0, ROWS, 0, "R9");
    frame(7, 1, 5, 0, "R5");
    frame(8, 1, ROWS, 0, "R5");
    frame(9, 1, ROWS, 1, "R5");
    step(0, 0, 0, 0, "R7");
    @(negedge clk_i);
    check_out();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule